// File: doc/BRIEF.md
# Pixel Transfer Control and Interrupt Unit

This block is the register-side controller of a two-dimensional pixel-transfer engine. Software programs the transfer geometry, the pixel formats and a fill colour through a simple word-addressed register port. It then launches a transfer by setting the start bit in the control word. The unit checks the configuration at the moment of launch. A bad configuration raises a configuration-error flag instead of starting. A good one sends a one-cycle start pulse to the pixel datapath, which is not part of this block.

While a transfer runs, the unit follows the datapath through a small handshake: done, error and line-watermark pulses come in, and start and hold go out. Software can suspend or abort the transfer. The control bits clear themselves when the transfer ends. Six event flags are collected in a status word. Each flag has its own enable bit and its own write-one-to-clear bit, and a single interrupt line combines the enabled flags. CLUT-load events arrive as separate input pulses from the datapath.

The sequencer has four states:
- **ST_IDLE**: no transfer is active.
- **ST_RUN**: a transfer is active and the handshake is live.
- **ST_HOLD**: the transfer is suspended and the handshake is frozen.
- **ST_DONE**: a one-cycle state entered after the datapath reports done or error.

Its transitions are:
- **launch**: ST_IDLE or ST_DONE to ST_RUN.
- **abort**: ST_RUN or ST_HOLD to ST_IDLE.
- **suspend**: ST_RUN to ST_HOLD.
- **resume**: ST_HOLD to ST_RUN.
- **finish**: ST_RUN to ST_DONE, on done or error.
- **retire**: ST_DONE to ST_IDLE.

Top module: `pxm_ctrl`

## Requirements
- R1: The control word is at word address 0. It holds start at bit 0, which reads 1 while a transfer is active, suspend at bit 1, abort at bit 2, the six enables at bits 8 to 13 and the mode at bits 16-17. A control write while a transfer is active leaves the mode unchanged. After reset, every register reads 0.
- R2: A start write with a valid configuration, made while no transfer is active, makes start read 1. It also drives `dp_start` high for exactly the one cycle after the write edge.
- R3: A configuration is invalid when any of these holds:
  - the line count is zero;
  - the pixels-per-line count is zero;
  - the output format code (format word bits 10:8) is above 4;
  - the mode is 1 or 2 and the source format code (format word bits 3:0) is above 11.

  A start write with an invalid configuration sets status bit 5, raises no `dp_start` and leaves start at 0.
- R4: A `dp_done` pulse while running sets status bit 1 (transfer complete) and returns start and suspend to 0.
- R5: A `dp_error` pulse while running sets status bit 0 (transfer error), does not set bit 1, and ends the transfer.
- R6: A `dp_line_mark` pulse while running sets status bit 2 (watermark).
- R7: `clut_access_err` sets status bit 3 and `clut_done` sets status bit 4 at any time. Neither one ever sets bit 1.
- R8: A write to the clear register at word address 2 clears each status flag whose data bit is 1. Bits written as 0 leave their flag unchanged. The status word is at word address 1.
- R9: `irq` is high exactly when some status flag is set and its enable (control bit 8 plus the flag index) is 1.
- R10: An abort write while a transfer is active returns the unit to idle at the next edge. It does not set the transfer-complete flag, and start and suspend read 0.
- R11: When suspend is set while running, `dp_hold` goes high and datapath pulses are ignored until suspend is cleared. Suspend cannot be set while no transfer is active.
- R12: The geometry register (word 3: lines at bit 0, pixels per line at bit 16), the format register (word 4) and the fill-colour register (word 5) accept writes only while no transfer is active. While a transfer is active they read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dp_start | output | 1 | One-cycle launch pulse to the datapath |
| dp_hold | output | 1 | Datapath freeze while suspended |
| dp_done | input | 1 | Datapath transfer finished |
| dp_error | input | 1 | Datapath transfer error |
| dp_line_mark | input | 1 | Watermark line completed |
| clut_done | input | 1 | CLUT load finished |
| clut_access_err | input | 1 | CLUT accessed during its load |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the unit with LINE_W=4 and PPL_W=4. With these widths, small random geometry draws hit a zero line count or a zero pixel count often, next to nonzero ones. The random source and output format codes sweep the full code space, so reserved codes in every mode come up in a few dozen launches. The narrow fields also let the protected-register checks compare readback words exactly.

// File: rtl/pxm_pkg.sv
package pxm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2,
        ST_DONE = 2'd3
    } xfer_state_e;

    localparam int NFLAG = 6;
    localparam int FL_XERR  = 0;
    localparam int FL_XDONE = 1;
    localparam int FL_WMARK = 2;
    localparam int FL_CAERR = 3;
    localparam int FL_CDONE = 4;
    localparam int FL_CFG   = 5;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_CLR  = 3'd2;
    localparam logic [2:0] A_GEOM = 3'd3;
    localparam logic [2:0] A_FMT  = 3'd4;
    localparam logic [2:0] A_FILL = 3'd5;

    localparam logic [3:0] SRC_FMT_LAST = 4'd11;
    localparam logic [2:0] DST_FMT_LAST = 3'd4;
endpackage

// File: rtl/pxm_cfg_check.sv
module pxm_cfg_check #(
    parameter int LINE_W = 16,
    parameter int PPL_W  = 14
) (
    input  logic [LINE_W-1:0] lines,
    input  logic [PPL_W-1:0]  ppl,
    input  logic [1:0]        mode,
    input  logic [3:0]        src_fmt,
    input  logic [2:0]        dst_fmt,
    output logic              cfg_ok
);
    import pxm_pkg::*;

    logic uses_src;

    always_comb begin
        uses_src = (mode == 2'd1) || (mode == 2'd2);
        cfg_ok   = (lines != '0) && (ppl != '0) && (dst_fmt <= DST_FMT_LAST)
                   && !(uses_src && (src_fmt > SRC_FMT_LAST));
    end
endmodule

// File: rtl/pxm_flags.sv
module pxm_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] en_vec,
    output logic [N-1:0] flags,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set_vec[i])
                flags[i] <= 1'b1;
            else if (clr_vec[i])
                flags[i] <= 1'b0;
        end
    end

    assign irq = |(flags & en_vec);
endmodule

// File: rtl/pxm_fsm.sv
module pxm_fsm (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  launch,
    input  logic                  abort_req,
    input  logic                  susp,
    input  logic                  dp_done,
    input  logic                  dp_error,
    output pxm_pkg::xfer_state_e  state,
    output pxm_pkg::xfer_state_e  state_nx,
    output logic                  busy,
    output logic                  running,
    output logic                  hold
);
    import pxm_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (launch) state_nx = ST_RUN;
            ST_RUN: begin
                if (abort_req)                state_nx = ST_IDLE;
                else if (dp_done || dp_error) state_nx = ST_DONE;
                else if (susp)                state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (abort_req)  state_nx = ST_IDLE;
                else if (!susp) state_nx = ST_RUN;
            end
            ST_DONE: state_nx = launch ? ST_RUN : ST_IDLE;
        endcase
    end

    always_comb begin
        running = (state == ST_RUN);
        hold    = (state == ST_HOLD);
        busy    = running || hold;
    end
endmodule

// File: rtl/pxm_ctrl.sv
module pxm_ctrl #(
    parameter int LINE_W = 16,
    parameter int PPL_W  = 14,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              dp_start,
    output logic              dp_hold,
    input  logic              dp_done,
    input  logic              dp_error,
    input  logic              dp_line_mark,
    input  logic              clut_done,
    input  logic              clut_access_err,
    output logic              irq
);
    import pxm_pkg::*;

    xfer_state_e state, state_nx;
    logic busy, running, hold;
    logic ctrl_wr, clr_wr, launch_try, launch_ok, abort_req, cfg_ok, in_run;
    logic [NFLAG-1:0] ien_q, flags, set_vec, clr_vec;
    logic [1:0]        mode_q;
    logic              susp_q, dp_start_q;
    logic [LINE_W-1:0] lines_q;
    logic [PPL_W-1:0]  ppl_q;
    logic [3:0]        src_fmt_q;
    logic [2:0]        dst_fmt_q;
    logic [31:0]       fill_q;

    always_comb begin
        ctrl_wr    = reg_we && (reg_addr == ADDR_W'(A_CTRL));
        clr_wr     = reg_we && (reg_addr == ADDR_W'(A_CLR));
        launch_try = ctrl_wr && reg_wdata[0] && !busy;
        launch_ok  = launch_try && cfg_ok;
        abort_req  = ctrl_wr && reg_wdata[2] && busy;
        in_run     = running && !abort_req;
    end

    pxm_cfg_check #(.LINE_W(LINE_W), .PPL_W(PPL_W)) u_cfg (
        .lines   (lines_q),
        .ppl     (ppl_q),
        .mode    (reg_wdata[17:16]),
        .src_fmt (src_fmt_q),
        .dst_fmt (dst_fmt_q),
        .cfg_ok  (cfg_ok)
    );

    pxm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch_ok),
        .abort_req (abort_req),
        .susp      (susp_q),
        .dp_done   (dp_done),
        .dp_error  (dp_error),
        .state     (state),
        .state_nx  (state_nx),
        .busy      (busy),
        .running   (running),
        .hold      (hold)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[FL_XERR]  = in_run && dp_error;
        set_vec[FL_XDONE] = in_run && dp_done && !dp_error;
        set_vec[FL_WMARK] = in_run && dp_line_mark;
        set_vec[FL_CAERR] = clut_access_err;
        set_vec[FL_CDONE] = clut_done;
        set_vec[FL_CFG]   = launch_try && !cfg_ok;
        clr_vec           = clr_wr ? reg_wdata[NFLAG-1:0] : '0;
    end

    pxm_flags #(.N(NFLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_vec  (ien_q),
        .flags   (flags),
        .irq     (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q      <= '0;
            mode_q     <= '0;
            susp_q     <= 1'b0;
            dp_start_q <= 1'b0;
            lines_q    <= '0;
            ppl_q      <= '0;
            src_fmt_q  <= '0;
            dst_fmt_q  <= '0;
            fill_q     <= '0;
        end else begin
            dp_start_q <= launch_ok;
            if (ctrl_wr) begin
                ien_q <= reg_wdata[8 +: NFLAG];
                if (!busy) mode_q <= reg_wdata[17:16];
            end
            if (state_nx != ST_RUN && state_nx != ST_HOLD)
                susp_q <= 1'b0;
            else if (ctrl_wr)
                susp_q <= reg_wdata[1];
            if (reg_we && !busy) begin
                if (reg_addr == ADDR_W'(A_GEOM)) begin
                    lines_q <= reg_wdata[LINE_W-1:0];
                    ppl_q   <= reg_wdata[16 +: PPL_W];
                end
                if (reg_addr == ADDR_W'(A_FMT)) begin
                    src_fmt_q <= reg_wdata[3:0];
                    dst_fmt_q <= reg_wdata[10:8];
                end
                if (reg_addr == ADDR_W'(A_FILL))
                    fill_q <= reg_wdata;
            end
        end
    end

    assign dp_start = dp_start_q;
    assign dp_hold  = hold;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(A_CTRL): begin
                reg_rdata[0]          = busy;
                reg_rdata[1]          = susp_q;
                reg_rdata[8 +: NFLAG] = ien_q;
                reg_rdata[17:16]      = mode_q;
            end
            ADDR_W'(A_STAT): reg_rdata[NFLAG-1:0] = flags;
            ADDR_W'(A_GEOM): begin
                reg_rdata[LINE_W-1:0] = lines_q;
                reg_rdata[16 +: PPL_W] = ppl_q;
            end
            ADDR_W'(A_FMT): begin
                reg_rdata[3:0]  = src_fmt_q;
                reg_rdata[10:8] = dst_fmt_q;
            end
            ADDR_W'(A_FILL): reg_rdata = fill_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pxm_ctrl_chk.sv
module pxm_ctrl_chk #(
    parameter int LINE_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input pxm_pkg::xfer_state_e state,
    input logic                 busy,
    input logic                 abort_req,
    input logic                 launch_try,
    input logic                 cfg_ok,
    input logic [5:0]           flags,
    input logic                 dp_done,
    input logic                 dp_start,
    input logic                 susp_q,
    input logic [LINE_W-1:0]    lines_q,
    input logic [1:0]           mode_q,
    input logic                 irq
);
    import pxm_pkg::*;

    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (state == ST_IDLE));

    assert_cfg_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_try && !cfg_ok) |=> (flags[5] && !busy));

    assert_start_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dp_start |-> (state == ST_RUN));

    assert_susp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !susp_q);

    assert_geom_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(lines_q));

    assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_q));

    assert_done_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(dp_done));

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 6'd0) |-> !irq);
endmodule

bind pxm_ctrl pxm_ctrl_chk #(.LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .busy       (busy),
    .abort_req  (abort_req),
    .launch_try (launch_try),
    .cfg_ok     (cfg_ok),
    .flags      (flags),
    .dp_done    (dp_done),
    .dp_start   (dp_start),
    .susp_q     (susp_q),
    .lines_q    (lines_q),
    .mode_q     (mode_q),
    .irq        (irq)
);

// File: tb/tb_pxm_ctrl.sv
module tb_pxm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 4;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic dp_start, dp_hold, irq;
    logic dp_done = 1'b0, dp_error = 1'b0, dp_line_mark = 1'b0;
    logic clut_done = 1'b0, clut_access_err = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pxm_ctrl #(.LINE_W(LW), .PPL_W(PW), .ADDR_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_start(dp_start),
        .dp_hold(dp_hold), .dp_done(dp_done), .dp_error(dp_error),
        .dp_line_mark(dp_line_mark), .clut_done(clut_done),
        .clut_access_err(clut_access_err), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: dp_done = 1'b1;
            1: dp_error = 1'b1;
            2: dp_line_mark = 1'b1;
            3: clut_done = 1'b1;
            default: clut_access_err = 1'b1;
        endcase
        @(negedge clk);
        dp_done = 0; dp_error = 0; dp_line_mark = 0; clut_done = 0; clut_access_err = 0;
    endtask

    function automatic bit cfg_valid(int lines, int ppl, int mode, int src, int dst);
        if (lines == 0 || ppl == 0) return 0;
        if (dst > 4) return 0;
        if ((mode == 1 || mode == 2) && src > 11) return 0;
        return 1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl after reset", v, 32'h0);
        rd(3'd1, v); chk("R1 status after reset", v, 32'h0);
        chk("R9 irq after reset", {31'b0, irq}, 32'h0);

        // R12 writes accepted while idle
        wr(3'd3, 32'h0008_0004);
        rd(3'd3, v); chk("R12 geom idle write", v, 32'h0008_0004);
        wr(3'd4, 32'h0000_0102);
        wr(3'd5, 32'hCAFE_1234);
        rd(3'd5, v); chk("R12 fill idle write", v, 32'hCAFE_1234);

        // R2 launch
        wr(3'd0, 32'h0001_3F01);
        chk("R2 dp_start pulse", {31'b0, dp_start}, 32'h1);
        rd(3'd0, v); chk("R2 start reads 1", v, 32'h0001_3F01);
        @(negedge clk);
        chk("R2 dp_start one cycle", {31'b0, dp_start}, 32'h0);

        // R1 mode frozen while running
        wr(3'd0, 32'h0002_3F00);
        rd(3'd0, v); chk("R1 mode frozen", v[17:16], 32'h1);
        // R12 protected regs frozen
        wr(3'd3, 32'h0003_0005);
        rd(3'd3, v); chk("R12 geom frozen", v, 32'h0008_0004);
        wr(3'd5, 32'h0);
        rd(3'd5, v); chk("R12 fill frozen", v, 32'hCAFE_1234);

        // R6 watermark, R9 irq
        pulse(2);
        rd(3'd1, v); chk("R6 watermark flag", v, 32'h4);
        chk("R9 irq with enabled flag", {31'b0, irq}, 32'h1);

        // R4 done
        pulse(0);
        rd(3'd1, v); chk("R4 done flag", v, 32'h6);
        rd(3'd0, v); chk("R4 start cleared", v[1:0], 32'h0);

        // R8 clear
        wr(3'd2, 32'h0);
        rd(3'd1, v); chk("R8 zero write no effect", v, 32'h6);
        wr(3'd2, 32'h2);
        rd(3'd1, v); chk("R8 clear bit1 only", v, 32'h4);
        wr(3'd2, 32'h3F);
        rd(3'd1, v); chk("R8 clear all", v, 32'h0);

        // R7 clut events, R9 masking
        wr(3'd0, 32'h0);
        pulse(3);
        rd(3'd1, v); chk("R7 clut done sets bit4 only", v, 32'h10);
        chk("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(3'd0, 32'h0000_1000);
        chk("R9 irq enabled bit12", {31'b0, irq}, 32'h1);
        pulse(4);
        rd(3'd1, v); chk("R7 clut access error bit3", v, 32'h18);
        wr(3'd2, 32'h3F);

        // R5 error
        wr(3'd0, 32'h0001_0001);
        pulse(1);
        rd(3'd1, v); chk("R5 error flag without done", v, 32'h1);
        rd(3'd0, v); chk("R5 transfer ended", v[0], 32'h0);
        wr(3'd2, 32'h3F);

        // R10 abort
        wr(3'd0, 32'h0000_0001);
        wr(3'd0, 32'h0000_0006);
        rd(3'd0, v); chk("R10 start and suspend cleared", v[2:0], 32'h0);
        pulse(0);
        rd(3'd1, v); chk("R10 no done after abort", v, 32'h0);

        // R11 suspend
        wr(3'd0, 32'h0000_0001);
        wr(3'd0, 32'h0000_0002);
        @(negedge clk);
        chk("R11 hold asserted", {31'b0, dp_hold}, 32'h1);
        pulse(0);
        rd(3'd1, v); chk("R11 done ignored while held", v, 32'h0);
        rd(3'd0, v); chk("R11 still active", v[1:0], 32'h3);
        wr(3'd0, 32'h0);
        @(negedge clk);
        chk("R11 hold released", {31'b0, dp_hold}, 32'h0);
        pulse(0);
        rd(3'd1, v); chk("R4 done after resume", v, 32'h2);
        rd(3'd0, v); chk("R4 suspend cleared at end", v[1:0], 32'h0);
        wr(3'd0, 32'h2);
        rd(3'd0, v); chk("R11 suspend not set when idle", v[1], 32'h0);
        wr(3'd2, 32'h3F);

        // R3 zero line count
        wr(3'd3, 32'h0004_0000);
        wr(3'd0, 32'h0000_0001);
        chk("R3 no dp_start", {31'b0, dp_start}, 32'h0);
        rd(3'd1, v); chk("R3 cfg flag", v, 32'h20);
        rd(3'd0, v); chk("R3 start stays 0", v[0], 32'h0);
        wr(3'd2, 32'h3F);

        // R3 random configurations
        for (int i = 0; i < 48; i++) begin
            int ln, pp, md, sf, df;
            bit ok;
            ln = int'($urandom % 4);
            pp = int'($urandom % 4);
            md = int'($urandom % 4);
            sf = int'($urandom % 16);
            df = int'($urandom % 8);
            ok = cfg_valid(ln, pp, md, sf, df);
            wr(3'd3, 32'(ln) | (32'(pp) << 16));
            wr(3'd4, 32'(sf) | (32'(df) << 8));
            wr(3'd0, 32'h1 | (32'(md) << 16));
            chk("R3 random dp_start", {31'b0, dp_start}, {31'b0, ok});
            rd(3'd1, v); chk("R3 random cfg flag", v, ok ? 32'h0 : 32'h20);
            rd(3'd0, v); chk("R2 random start bit", v[0], {31'b0, ok});
            if (ok) begin
                pulse(0);
                rd(3'd1, v); chk("R4 random done flag", v, 32'h2);
            end
            wr(3'd2, 32'h3F);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule